// File: doc/BRIEF.md
# First-Ready Request Picker for a DRAM Scheduler

This block chooses which pending request in a small memory-controller queue is served next. Every queue slot gives a valid flag and a target (rank, bank within the rank, row). A bank tracker supplies, for each bank in the channel, whether a row is open, which row it is, and the earliest time the bank may be activated. The scheduler also supplies the rank that the previous burst went to, and a flag that says the controller is turning the bus around between reads and writes.

A mode input picks one of two policies. In plain arrival order, the oldest valid slot wins. In first-ready order, the block first narrows the candidates to the last burst's rank, unless a turnaround is flagged. Among those candidates, the oldest row hit wins. When no candidate hits, the block builds a mask of the banks whose activate-allowed time is the smallest among the banks the candidates need. The oldest candidate aimed at one of those banks then wins. The decision is made combinationally from the inputs and is registered once. The result is a valid bit and a slot index one clock after the inputs are presented.

Top module: `frfcfs_picker`

## Requirements
- R1: When no slot is valid, `pick_valid` is 0 in the following cycle; when any slot is valid, `pick_valid` is 1 in the following cycle.
- R2: With `mode_frfcfs` = 0 the chosen index is the lowest-numbered valid slot, regardless of row state, rank or timing.
- R3: With `mode_frfcfs` = 1, a candidate whose bank has its open flag set and whose stored row equals the slot's row is chosen ahead of any candidate without such a hit.
- R4: Age breaks every tie: among equally preferred slots the lowest index wins (index 0 is the oldest).
- R5: With `mode_frfcfs` = 1 and no candidate hit, the chosen slot targets a bank whose activate-allowed time is the minimum over the banks targeted by candidates.
- R6: With `switch_cmd` = 0 and at least one valid slot whose rank equals `last_rank`, only slots of that rank are candidates, even if a slot of another rank hits an open row.
- R7: With `switch_cmd` = 1, or when no valid slot matches `last_rank`, all valid slots are candidates.
- R8: The flat bank number is rank × BANKS_PER_RANK + bank, so bank-tracker entry k belongs only to that one rank/bank pair; an open row in one rank does not make a hit for the same bank number in another rank.
- R9: The output is registered: a change of inputs shows on `pick_valid`/`pick_idx` only after the next rising clock edge, and reset clears `pick_valid`.

Top module ports (defaults: QDEPTH=8, RANKS=2, BANKS_PER_RANK=8, ROW_W=14, TIME_W=16; RW, BW, IW are the ceiling log2 of RANKS, BANKS_PER_RANK, QDEPTH, each at least 1; NBANK = RANKS × BANKS_PER_RANK, at most 64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_frfcfs | input | 1 | 0: arrival order, 1: first-ready order |
| switch_cmd | input | 1 | Read/write turnaround in progress; disables rank preference |
| last_rank | input | RW | Rank of the previously issued burst |
| q_valid | input | QDEPTH | Per-slot valid; bit i is slot i |
| q_rank | input | QDEPTH*RW | Slot i rank at bits [i*RW +: RW] |
| q_bank | input | QDEPTH*BW | Slot i bank within rank at bits [i*BW +: BW] |
| q_row | input | QDEPTH*ROW_W | Slot i row at bits [i*ROW_W +: ROW_W] |
| bank_open | input | NBANK | Bit k set: flat bank k has an open row |
| bank_row | input | NBANK*ROW_W | Open row of flat bank k at [k*ROW_W +: ROW_W] |
| bank_act_at | input | NBANK*TIME_W | Activate-allowed time of flat bank k at [k*TIME_W +: TIME_W] |
| pick_valid | output | 1 | A slot was chosen |
| pick_idx | output | IW | Index of the chosen slot |

## Verification
Rank preference and row-hit preference act in the same evaluation. The interesting case is a hit in a rank other than `last_rank` while a non-hitting slot sits in the preferred rank. The bench builds that case directly and then repeats it with `switch_cmd` raised, expecting the picked slot to move from the in-rank miss to the out-of-rank hit. Seeded random queues with narrow rows and times make hits, rank matches and activate-time ties coincide often. Every pick is compared with a model written from the requirements.

// File: rtl/frfcfs_picker_pkg.sv
package frfcfs_picker_pkg;
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pick_oldest.sv
module pick_oldest #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/earliest_bank_mask.sv
module earliest_bank_mask #(
   parameter int unsigned NBANK = 16,
   parameter int unsigned TW    = 16
) (
   input  logic [NBANK-1:0]    need,
   input  logic [NBANK*TW-1:0] act_at,
   output logic [NBANK-1:0]    mask
);
   logic [TW-1:0] t_of [NBANK];
   logic [TW-1:0] t_min;

   for (genvar b = 0; b < NBANK; b++) begin : g_unpack
      assign t_of[b] = act_at[b*TW +: TW];
   end

   always_comb begin
      t_min = '1;
      for (int b = 0; b < NBANK; b++) begin
         if (need[b] && (t_of[b] < t_min)) t_min = t_of[b];
      end
      for (int b = 0; b < NBANK; b++) begin
         mask[b] = need[b] && (t_of[b] == t_min);
      end
   end
endmodule

// File: rtl/frfcfs_picker.sv
module frfcfs_picker
   import frfcfs_picker_pkg::*;
#(
   parameter int unsigned QDEPTH         = 8,
   parameter int unsigned RANKS          = 2,
   parameter int unsigned BANKS_PER_RANK = 8,
   parameter int unsigned ROW_W          = 14,
   parameter int unsigned TIME_W         = 16,
   parameter bit          RANK_PREF      = 1'b1,
   localparam int unsigned RW    = idx_bits(RANKS),
   localparam int unsigned BW    = idx_bits(BANKS_PER_RANK),
   localparam int unsigned IW    = idx_bits(QDEPTH),
   localparam int unsigned NBANK = RANKS * BANKS_PER_RANK
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode_frfcfs,
   input  logic                    switch_cmd,
   input  logic [RW-1:0]           last_rank,
   input  logic [QDEPTH-1:0]       q_valid,
   input  logic [QDEPTH*RW-1:0]    q_rank,
   input  logic [QDEPTH*BW-1:0]    q_bank,
   input  logic [QDEPTH*ROW_W-1:0] q_row,
   input  logic [NBANK-1:0]        bank_open,
   input  logic [NBANK*ROW_W-1:0]  bank_row,
   input  logic [NBANK*TIME_W-1:0] bank_act_at,
   output logic                    pick_valid,
   output logic [IW-1:0]           pick_idx
);
   localparam int unsigned BID_W = idx_bits(NBANK);

   if (NBANK > 64) begin : g_bad_banks
      $error("frfcfs_picker: more than 64 banks in total");
   end
   if (QDEPTH < 1) begin : g_bad_depth
      $error("frfcfs_picker: QDEPTH must be at least 1");
   end

   logic [ROW_W-1:0] open_row [NBANK];
   logic [BID_W-1:0] ent_bid  [QDEPTH];
   logic [QDEPTH-1:0] ent_hit, ent_same, cand, cand_hit, cand_bank;
   logic [NBANK-1:0]  bank_need, bank_early;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign open_row[b] = bank_row[b*ROW_W +: ROW_W];
   end

   // R8: flat bank number = rank * BANKS_PER_RANK + bank
   for (genvar e = 0; e < QDEPTH; e++) begin : g_ent
      logic [RW-1:0] rk;
      logic [BW-1:0] bk;
      assign rk         = q_rank[e*RW +: RW];
      assign bk         = q_bank[e*BW +: BW];
      assign ent_bid[e] = BID_W'(BID_W'(rk) * BID_W'(BANKS_PER_RANK) + BID_W'(bk));
      assign ent_hit[e] = bank_open[ent_bid[e]] && (open_row[ent_bid[e]] == q_row[e*ROW_W +: ROW_W]);
      assign ent_same[e] = q_valid[e] && (rk == last_rank);
   end

   // R6, R7: candidate narrowing to the last burst's rank
   if (RANK_PREF && (RANKS > 1)) begin : g_rank_pref
      assign cand = (!switch_cmd && (|ent_same)) ? ent_same : q_valid;
   end else begin : g_no_rank_pref
      assign cand = q_valid;
   end

   assign cand_hit = cand & ent_hit;

   always_comb begin
      for (int b = 0; b < NBANK; b++) begin
         bank_need[b] = 1'b0;
         for (int e = 0; e < QDEPTH; e++) begin
            if (cand[e] && (ent_bid[e] == BID_W'(b))) bank_need[b] = 1'b1;
         end
      end
   end

   earliest_bank_mask #(.NBANK(NBANK), .TW(TIME_W)) u_mask (
      .need   (bank_need),
      .act_at (bank_act_at),
      .mask   (bank_early)
   );

   for (genvar e = 0; e < QDEPTH; e++) begin : g_cand
      assign cand_bank[e] = cand[e] && bank_early[ent_bid[e]];
   end

   logic          f_any, h_any, b_any;
   logic [IW-1:0] f_idx, h_idx, b_idx;

   pick_oldest #(.N(QDEPTH), .IW(IW)) u_fcfs (.req(q_valid),   .found(f_any), .idx(f_idx));
   pick_oldest #(.N(QDEPTH), .IW(IW)) u_hit  (.req(cand_hit),  .found(h_any), .idx(h_idx));
   pick_oldest #(.N(QDEPTH), .IW(IW)) u_bank (.req(cand_bank), .found(b_any), .idx(b_idx));

   logic [IW-1:0] nxt_idx;
   always_comb begin
      if (!mode_frfcfs)  nxt_idx = f_idx;
      else if (h_any)    nxt_idx = h_idx;
      else               nxt_idx = b_idx;
   end

   // R9: one register stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pick_valid <= 1'b0;
         pick_idx   <= '0;
      end else begin
         pick_valid <= f_any;
         pick_idx   <= nxt_idx;
      end
   end
endmodule

// File: rtl/frfcfs_picker_chk.sv
module frfcfs_picker_chk #(
   parameter int unsigned QDEPTH = 8,
   parameter int unsigned IW     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_frfcfs,
   input logic [QDEPTH-1:0] q_valid,
   input logic              pick_valid,
   input logic [IW-1:0]     pick_idx
);
   // R1
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid == '0) |=> !pick_valid);

   // R1
   busy_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid != '0) |=> pick_valid);

   // R9
   pick_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> ((($past(q_valid) >> pick_idx) & QDEPTH'(1)) != '0));

   // R2
   fcfs_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_valid && !$past(mode_frfcfs)) |->
         (($past(q_valid) & ((QDEPTH'(1) << pick_idx) - QDEPTH'(1))) == '0));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> !pick_valid);
endmodule

bind frfcfs_picker frfcfs_picker_chk #(.QDEPTH(QDEPTH), .IW(IW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_frfcfs (mode_frfcfs),
   .q_valid     (q_valid),
   .pick_valid  (pick_valid),
   .pick_idx    (pick_idx)
);

// File: tb/frfcfs_picker_tb.sv
module frfcfs_picker_tb;
   localparam int CLK_PERIOD = 10;
   localparam int QD = 8, RANKS = 2, BPR = 4, ROW_W = 2, TW = 3;
   localparam int RW = 1, BW = 2, IW = 3, NB = RANKS * BPR;

   logic clk = 1'b0, rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic mode, sw;
   logic [RW-1:0] lr;
   logic v [QD];
   logic [RW-1:0] rk [QD];
   logic [BW-1:0] bk [QD];
   logic [ROW_W-1:0] rw [QD];
   logic bo [NB];
   logic [ROW_W-1:0] br [NB];
   logic [TW-1:0] ba [NB];

   logic [QD-1:0] q_valid;
   logic [QD*RW-1:0] q_rank;
   logic [QD*BW-1:0] q_bank;
   logic [QD*ROW_W-1:0] q_row;
   logic [NB-1:0] bank_open;
   logic [NB*ROW_W-1:0] bank_row;
   logic [NB*TW-1:0] bank_act_at;
   logic pick_valid;
   logic [IW-1:0] pick_idx;

   always_comb begin
      for (int e = 0; e < QD; e++) begin
         q_valid[e] = v[e];
         q_rank[e*RW +: RW] = rk[e];
         q_bank[e*BW +: BW] = bk[e];
         q_row[e*ROW_W +: ROW_W] = rw[e];
      end
      for (int b = 0; b < NB; b++) begin
         bank_open[b] = bo[b];
         bank_row[b*ROW_W +: ROW_W] = br[b];
         bank_act_at[b*TW +: TW] = ba[b];
      end
   end

   frfcfs_picker #(.QDEPTH(QD), .RANKS(RANKS), .BANKS_PER_RANK(BPR),
                   .ROW_W(ROW_W), .TIME_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_frfcfs(mode), .switch_cmd(sw),
      .last_rank(lr), .q_valid(q_valid), .q_rank(q_rank), .q_bank(q_bank),
      .q_row(q_row), .bank_open(bank_open), .bank_row(bank_row),
      .bank_act_at(bank_act_at), .pick_valid(pick_valid), .pick_idx(pick_idx));

   int checks = 0, errors = 0;

   function automatic int bid(input int e);
      return int'(rk[e]) * BPR + int'(bk[e]);
   endfunction

   // Model written from R1..R8; returns -1 for no pick
   function automatic int ref_pick();
      logic same [QD];
      logic use_e [QD];
      logic any_same = 1'b0;
      int tmin = 1 << TW;
      for (int e = 0; e < QD; e++) begin
         same[e] = v[e] && (rk[e] == lr);
         if (same[e]) any_same = 1'b1;
      end
      if (!mode) begin
         for (int e = 0; e < QD; e++) if (v[e]) return e;
         return -1;
      end
      for (int e = 0; e < QD; e++) use_e[e] = (!sw && any_same) ? same[e] : v[e];
      for (int e = 0; e < QD; e++)
         if (use_e[e] && bo[bid(e)] && br[bid(e)] == rw[e]) return e;
      for (int e = 0; e < QD; e++)
         if (use_e[e] && int'(ba[bid(e)]) < tmin) tmin = int'(ba[bid(e)]);
      for (int e = 0; e < QD; e++)
         if (use_e[e] && int'(ba[bid(e)]) == tmin) return e;
      return -1;
   endfunction

   task automatic check(input string req, input int exp);
      int got = pick_valid ? int'(pick_idx) : -1;
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got pick %0d expected %0d (-1 = none)", req, got, exp);
      end
   endtask

   task automatic clear_all();
      mode = 1'b1; sw = 1'b0; lr = '0;
      for (int e = 0; e < QD; e++) begin
         v[e] = 1'b0; rk[e] = '0; bk[e] = '0; rw[e] = '0;
      end
      for (int b = 0; b < NB; b++) begin
         bo[b] = 1'b0; br[b] = '0; ba[b] = '1;
      end
   endtask

   // inputs are set just after a falling edge; result checked one cycle later
   task automatic step(input string req);
      int exp = ref_pick();
      @(negedge clk);
      check(req, exp);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      clear_all();
      v[0] = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 reset clears valid", -1);
      rst_n = 1'b1;
      clear_all();
      step("R1 empty queue");

      // R2: arrival order ignores a younger hit
      clear_all(); mode = 1'b0;
      v[3] = 1; v[5] = 1; bk[5] = 2; rw[5] = 1; bo[2] = 1; br[2] = 1;
      step("R2 fcfs oldest");

      // R3: younger hit beats older miss
      mode = 1'b1;
      step("R3 row hit first");

      // R4: two hits, lower index wins
      clear_all();
      v[2] = 1; v[6] = 1; bk[2] = 1; bk[6] = 1; rw[2] = 3; rw[6] = 3;
      bo[1] = 1; br[1] = 3;
      step("R4 oldest hit");

      // R5: no hit, earliest bank wins
      clear_all();
      v[0] = 1; bk[0] = 0; ba[0] = 6;
      v[3] = 1; bk[3] = 3; ba[3] = 2;
      step("R5 earliest bank");

      // R4: activate-time tie, lower index wins
      ba[0] = 2;
      step("R4 tie on bank time");

      // R9: output holds until the next edge
      clear_all(); v[7] = 1;
      #1 check("R9 holds before edge", 0);
      step("R9 updates after edge");

      // R6: in-rank miss beats out-of-rank hit
      clear_all(); lr = 1;
      v[0] = 1; rk[0] = 0; bk[0] = 1; rw[0] = 2; bo[1] = 1; br[1] = 2;
      v[2] = 1; rk[2] = 1; bk[2] = 1; rw[2] = 0;
      step("R6 same rank preferred");

      // R7: turnaround lifts rank preference
      sw = 1;
      step("R7 switch disables rank pref");

      // R7: no slot in last rank
      sw = 0; lr = 1; v[2] = 0;
      step("R7 no match falls back");

      // R8: open row of rank0 bank1 is not a hit for rank1 bank1
      clear_all(); lr = 1;
      v[1] = 1; rk[1] = 1; bk[1] = 1; rw[1] = 2; ba[5] = 4;
      v[4] = 1; rk[4] = 1; bk[4] = 2; rw[4] = 0; ba[6] = 1;
      bo[1] = 1; br[1] = 2;
      step("R8 flat bank per rank");

      // random mix exercising R1..R8
      for (int n = 0; n < 400; n++) begin
         mode = ($urandom % 4) != 0;
         sw = $urandom % 2;
         lr = RW'($urandom);
         for (int e = 0; e < QD; e++) begin
            v[e] = ($urandom % 3) == 0;
            rk[e] = RW'($urandom); bk[e] = BW'($urandom); rw[e] = ROW_W'($urandom);
         end
         for (int b = 0; b < NB; b++) begin
            bo[b] = $urandom % 2; br[b] = ROW_W'($urandom); ba[b] = TW'($urandom);
         end
         step("R3 R5 R6 R7 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule